// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block sits on the inbound write path of a host bridge and turns memory-write messages from downstream devices into interrupt vectors. Every inbound write is compared against a programmed 64-bit target address and a data pattern. A write that matches on both sets one status bit, and the low bits of the message data pick which one. The block has 32 vectors. It keeps a pending-status register and a mask register, and it drives one combined interrupt line toward the host processor.

Software programs the block through a single-cycle register write strobe with a 3-bit select. The target address is written as a low word and a high word. Bit 0 of the low word is the receiver enable, because a real target address is always 4-byte aligned. A pattern word holds a compare mask in its upper half and a compare value in its lower half. The usual programming is 0xFFE06540, which accepts message data of 0x6540 with the vector number in bits 4:0. Three further selects are write-1 strobes:

- one acknowledges (clears) pending status bits;
- one masks vectors;
- one unmasks vectors.

The status and mask registers are brought out as ports for the interrupt handler.

Top module: `msi_rx`

## Requirements
- R1: After synchronous reset, all status bits are 0 and all mask bits are 1. The interrupt line is low and the receiver is disabled, so messages are ignored until software sets the enable.
- R2: The receiver is enabled only while bit 0 of the low target word (select 0) is 1. With that bit at 0, no message changes the status register.
- R3: A message is accepted only when bits 63:1 of its address equal bits 63:1 of the target. The target is formed from the high word (select 1) and the low word (select 0). Bit 0 of the message address is not compared.
- R4: A message is accepted only when its data bits 15:0, ANDed with pattern bits 31:16, equal pattern bits 15:0 (pattern written at select 2). Message data bits 31:16 are not compared.
- R5: An accepted message sets the status bit whose index equals message data bits 4:0. The bit is visible on `status_o` after the next rising clock edge.
- R6: An accepted message sets its status bit even while that vector is masked.
- R7: Writing at select 3 clears exactly the status bits written as 1. All other status bits keep their value.
- R8: Writing at select 4 sets the mask bits written as 1. Writing at select 5 clears the mask bits written as 1. Mask bits written as 0 are unchanged.
- R9: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R10: If an accepted message and an acknowledge hit the same status bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 target low, 1 target high, 2 pattern, 3 acknowledge, 4 mask set, 5 mask clear |
| cfg_wdata_i | input | 32 | Register write data |
| msg_vld_i | input | 1 | Inbound memory write valid |
| msg_addr_i | input | 64 | Inbound write address |
| msg_data_i | input | 32 | Inbound write data |
| status_o | output | 32 | Pending vector status |
| mask_o | output | 32 | Vector mask, 1 = masked |
| irq_o | output | 1 | Combined interrupt to host |

## Verification
The assertions check properties that hold on every cycle:

- an accepted message sets at most one vector;
- nothing is accepted while the receiver is disabled;
- every vector set by a message shows as pending on the next cycle, even if an acknowledge hits it at the same time;
- a pending bit never drops unless it was acknowledged;
- a mask-set write always lands;
- the interrupt line is never high with nothing pending.

Only the bench's scenarios can show that the address and data compare accept and reject the right messages. The scenarios also show that the vector index decodes to the intended bit, that an acknowledge leaves unwritten bits alone, and that the interrupt line follows masking and unmasking of a vector that is already pending.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_TGT_LO  = 3'd0,
        SEL_TGT_HI  = 3'd1,
        SEL_PATTERN = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_MSK_SET = 3'd4,
        SEL_MSK_CLR = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-2:0] tgt;
        logic [HALF_W-1:0] cmp_mask;
        logic [HALF_W-1:0] cmp_val;
    } rx_cfg_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } rx_msg_t;

    function automatic logic data_hit(input logic [HALF_W-1:0] d,
                                      input logic [HALF_W-1:0] m,
                                      input logic [HALF_W-1:0] v);
        return (d & m) == v;
    endfunction

endpackage

// File: rtl/msi_rx_cfg.sv
module msi_rx_cfg
    import msi_rx_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    output rx_cfg_t           cfg_o,
    output logic [NVEC-1:0]   ack_o,
    output logic [NVEC-1:0]   mset_o,
    output logic [NVEC-1:0]   mclr_o
);
    logic [WORD_W-1:0] lo_q, hi_q, pat_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(sel_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q  <= '0;
            hi_q  <= '0;
            pat_q <= '0;
        end else if (we_i) begin
            case (sel)
                SEL_TGT_LO:  lo_q  <= wdata_i;
                SEL_TGT_HI:  hi_q  <= wdata_i;
                SEL_PATTERN: pat_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_o.en       = lo_q[0];
        cfg_o.tgt      = {hi_q, lo_q[WORD_W-1:1]};
        cfg_o.cmp_mask = pat_q[WORD_W-1:HALF_W];
        cfg_o.cmp_val  = pat_q[HALF_W-1:0];
    end

    assign ack_o  = (we_i && sel == SEL_ACK)     ? wdata_i[NVEC-1:0] : '0;
    assign mset_o = (we_i && sel == SEL_MSK_SET) ? wdata_i[NVEC-1:0] : '0;
    assign mclr_o = (we_i && sel == SEL_MSK_CLR) ? wdata_i[NVEC-1:0] : '0;

endmodule

// File: rtl/msi_rx_match.sv
module msi_rx_match
    import msi_rx_pkg::*;
#(
    parameter int NVEC = 32,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  rx_cfg_t         cfg_i,
    input  rx_msg_t         msg_i,
    output logic [NVEC-1:0] set_o
);
    logic             addr_ok, pat_ok, accept;
    logic [VEC_W-1:0] idx;
    logic [NVEC-1:0]  dec;

    assign addr_ok = msg_i.addr[ADDR_W-1:1] == cfg_i.tgt;
    assign pat_ok  = data_hit(msg_i.data[HALF_W-1:0], cfg_i.cmp_mask, cfg_i.cmp_val);
    assign accept  = msg_i.vld && cfg_i.en && addr_ok && pat_ok;
    assign idx     = msg_i.data[VEC_W-1:0];

    for (genvar k = 0; k < NVEC; k++) begin : g_dec
        assign dec[k] = (idx == VEC_W'(k));
    end

    assign set_o = accept ? dec : '0;

    // R5: one message selects at most one vector
    p_one_vec_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(set_o));

    // R2: nothing is accepted while the enable bit is low
    p_disabled_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_i.en |-> set_o == '0);

endmodule

// File: rtl/msi_rx_vec.sv
module msi_rx_vec #(
    parameter int NVEC = 32
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NVEC-1:0] set_i,
    input  logic [NVEC-1:0] ack_i,
    input  logic [NVEC-1:0] mset_i,
    input  logic [NVEC-1:0] mclr_i,
    output logic [NVEC-1:0] status_o,
    output logic [NVEC-1:0] mask_o,
    output logic            irq_o
);
    logic [NVEC-1:0] st_q, msk_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= '0;
            msk_q <= '1;
        end else begin
            for (int k = 0; k < NVEC; k++) begin
                if (set_i[k])      st_q[k] <= 1'b1;
                else if (ack_i[k]) st_q[k] <= 1'b0;
                if (mset_i[k])      msk_q[k] <= 1'b1;
                else if (mclr_i[k]) msk_q[k] <= 1'b0;
            end
        end
    end

    assign status_o = st_q;
    assign mask_o   = msk_q;
    assign irq_o    = |(st_q & ~msk_q);

    // R5, R10: every vector set by a message is pending next cycle, acknowledge or not
    p_set_lands_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i)));

    // R7: a pending bit falls only when acknowledged
    p_no_spurious_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((($past(st_q) & ~$past(ack_i)) & ~st_q) == '0));

    // R8: a mask-set write always takes effect
    p_mask_set_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (mset_i != '0) |=> ((msk_q & $past(mset_i)) == $past(mset_i)));

endmodule

// File: rtl/msi_rx.sv
module msi_rx
    import msi_rx_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              msg_vld_i,
    input  logic [ADDR_W-1:0] msg_addr_i,
    input  logic [WORD_W-1:0] msg_data_i,
    output logic [NVEC-1:0]   status_o,
    output logic [NVEC-1:0]   mask_o,
    output logic              irq_o
);
    rx_cfg_t         cfg;
    rx_msg_t         msg;
    logic [NVEC-1:0] ack, mset, mclr, setv;

    assign msg.vld  = msg_vld_i;
    assign msg.addr = msg_addr_i;
    assign msg.data = msg_data_i;

    msi_rx_cfg #(.NVEC(NVEC)) u_cfg (
        .clk_i(clk_i), .rst_i(rst_i), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .wdata_i(cfg_wdata_i), .cfg_o(cfg), .ack_o(ack), .mset_o(mset), .mclr_o(mclr)
    );

    msi_rx_match #(.NVEC(NVEC)) u_match (
        .clk_i(clk_i), .rst_i(rst_i), .cfg_i(cfg), .msg_i(msg), .set_o(setv)
    );

    msi_rx_vec #(.NVEC(NVEC)) u_vec (
        .clk_i(clk_i), .rst_i(rst_i), .set_i(setv), .ack_i(ack),
        .mset_i(mset), .mclr_i(mclr), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    // R9: the line never rises with nothing pending
    p_irq_needs_src_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> status_o != '0);

    // R1: first cycle out of reset shows the cleared, fully masked state
    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (status_o == '0 && mask_o == '1 && !irq_o));

endmodule

// File: tb/sim_msi_rx.sv
module sim_msi_rx;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        msg_vld;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [31:0] status, mask;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    msi_rx u0 (
        .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .msg_vld_i(msg_vld), .msg_addr_i(msg_addr),
        .msg_data_i(msg_data), .status_o(status), .mask_o(mask), .irq_o(irq)
    );

    // {address, data, accepted, vector}
    localparam logic [101:0] TBL [0:8] = '{
        {64'h0000_0001_2345_6780, 32'h0000_6540, 1'b1, 5'd0},
        {64'h0000_0001_2345_6781, 32'h0000_655F, 1'b1, 5'd31},
        {64'h0000_0001_2345_6780, 32'hABCD_6547, 1'b1, 5'd7},
        {64'h0000_0000_2345_6780, 32'h0000_6540, 1'b0, 5'd0},
        {64'h0000_0001_2345_6784, 32'h0000_6540, 1'b0, 5'd0},
        {64'h0000_0001_2345_6780, 32'h0000_6560, 1'b0, 5'd0},
        {64'h0000_0001_2345_6780, 32'h0000_7540, 1'b0, 5'd0},
        {64'h0000_0001_2345_6780, 32'h0000_6550, 1'b1, 5'd16},
        {64'h0000_0001_2345_6782, 32'h0000_6540, 1'b0, 5'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus; returns on the falling edge after the update
    task automatic cycle(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                         input logic mv, input logic [63:0] ma, input logic [31:0] md);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        msg_vld = mv; msg_addr = ma; msg_data = md;
        @(negedge clk);
        cfg_we = 1'b0; msg_vld = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
        cycle(1'b1, sel, wd, 1'b0, 64'h0, 32'h0);
    endtask

    task automatic send(input logic [63:0] ma, input logic [31:0] md);
        cycle(1'b0, 3'd0, 32'h0, 1'b1, ma, md);
    endtask

    localparam logic [63:0] TGT = 64'h0000_0001_2345_6780;

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        msg_vld = 1'b0; msg_addr = '0; msg_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", status, 32'h0);
        check("R1 mask", mask, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R1/R2: zero target and pattern would match this message; only enable blocks it
        send(64'h0, 32'h0);
        check("R2 disabled at reset", status, 32'h0);

        wr(3'd1, 32'h0000_0001);
        wr(3'd0, 32'h2345_6780);
        wr(3'd2, 32'hFFE0_6540);
        send(TGT, 32'h6540);
        check("R2 enable bit low", status, 32'h0);

        wr(3'd0, 32'h2345_6781);
        wr(3'd5, 32'hFFFF_FFFF);
        check("R8 unmask all", mask, 32'h0);

        // R3 R4 R5 table walk
        for (int i = 0; i < 9; i++) begin
            logic [31:0] exp_st;
            exp_st = TBL[i][5] ? (32'h1 << TBL[i][4:0]) : 32'h0;
            send(TBL[i][101:38], TBL[i][37:6]);
            check($sformatf("R3/R4/R5 vec%0d status", i), status, exp_st);
            check($sformatf("R9 vec%0d irq", i), {31'b0, irq}, {31'b0, TBL[i][5]});
            wr(3'd3, 32'hFFFF_FFFF);
            check($sformatf("R7 vec%0d ack all", i), status, 32'h0);
        end

        // R6: masked vector still latches, line stays low
        wr(3'd4, 32'h0000_0008);
        check("R8 mask set bit3", mask, 32'h0000_0008);
        send(TGT, 32'h6543);
        check("R6 masked set", status, 32'h0000_0008);
        check("R9 masked no irq", {31'b0, irq}, 32'h0);
        wr(3'd5, 32'h0000_0008);
        check("R8 mask clear bit3", mask, 32'h0);
        check("R9 unmask raises irq", {31'b0, irq}, 32'h1);

        // R7: acknowledge leaves unwritten bits
        send(TGT, 32'h6549);
        check("R5 two pending", status, 32'h0000_0208);
        wr(3'd3, 32'h0);
        check("R7 zero ack", status, 32'h0000_0208);
        wr(3'd3, 32'h0000_0008);
        check("R7 partial ack", status, 32'h0000_0200);
        wr(3'd4, 32'h0000_0200);
        check("R9 mask pending", {31'b0, irq}, 32'h0);
        wr(3'd5, 32'h0000_0200);
        wr(3'd3, 32'hFFFF_FFFF);

        // R10: set and acknowledge of vector 5 in one cycle
        cycle(1'b1, 3'd3, 32'h0000_0020, 1'b1, TGT, 32'h6545);
        check("R10 set wins", status, 32'h0000_0020);
        wr(3'd3, 32'h0000_0020);

        // R2: disabling again
        wr(3'd0, 32'h2345_6780);
        send(TGT, 32'h6541);
        check("R2 disabled later", status, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule